// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic, logic and shift stage of an 8-bit accumulator processor. For each request it takes an operation code, a primary operand (the accumulator, an index register or a fetched memory byte, chosen by the caller), a second operand and the incoming carry flag. It returns an 8-bit result together with new negative (N), overflow (V), zero (Z) and carry (C) flag values. A result write-enable and one write-enable per flag tell the surrounding core which state to update. Flags that an operation leaves alone are driven as zero, so the core can merge with a plain mask.

A request is taken when `valid_i` is high at a rising clock edge. The outcome appears on the outputs one cycle later, marked by `valid_o`. Between requests the outputs hold their last value. Arithmetic is always binary; a decimal mode does not exist in this block. Operand fetch and addressing are handled by the caller.

Top module: `alu8_flags`

## Requirements
- R1: A request with `valid_i` high at a clock edge raises `valid_o` for exactly the following cycle. With `valid_i` low, `valid_o` is low and `res_o`, `res_we_o`, `flags_o` and `flags_we_o` keep their values.
- R2: Code 3 (add with carry) gives res = low 8 bits of acc + opd + carry_i. C is set when that sum exceeds 0xFF. V is set when bit 7 of the result differs from bit 7 of both inputs. All four flags are written.
- R3: Code 4 (subtract with borrow) computes acc + ~opd + carry_i, so carry_i = 1 means no borrow. C is the carry out of that sum. V uses the add rule with the operand inverted. All four flags are written.
- R4: Code 5 (compare) sets C when acc >= opd (unsigned), sets Z when they are equal, and sets N to bit 7 of acc - opd. It writes no result (`res_we_o` = 0, `res_o` unchanged) and leaves V unwritten.
- R5: Code 6 (bit test) sets Z when (acc & opd) is zero, copies opd bit 7 into N and opd bit 6 into V. It writes neither a result nor C.
- R6: Codes 0, 1 and 2 give acc OR opd, acc AND opd and acc XOR opd. They write the result, N and Z only.
- R7: Code 7 shifts acc left, moving bit 7 into C and shifting a 0 into bit 0. Code 8 shifts right, moving bit 0 into C and shifting a 0 into bit 7. Both write the result, N, Z and C, and leave V unwritten.
- R8: Code 9 rotates acc left with carry_i entering bit 0. Code 10 rotates right with carry_i entering bit 7. The bit shifted out goes to C. Flag writes are the same as in R7.
- R9: Code 11 returns acc + 1 with 0xFF wrapping to 0x00. Code 12 returns acc - 1 with 0x00 wrapping to 0xFF. Both write only N and Z.
- R10: Every operation that writes a result sets Z when the 8-bit result is zero and sets N equal to result bit 7.
- R11: Codes 13 to 15 are accepted and raise `valid_o`, but write no result and no flag.
- R12: While `rst_ni` is low, `valid_o`, `res_o`, `res_we_o`, `flags_o` and `flags_we_o` are all zero.
- R13: `flags_o` and `flags_we_o` use bit 0 = C, bit 1 = Z, bit 2 = V, bit 3 = N. Any `flags_o` bit whose write-enable is clear reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 4 | Operation code (see R2 to R11) |
| acc_i | input | 8 | Primary operand (accumulator, index register or shift/step source) |
| opd_i | input | 8 | Second operand |
| carry_i | input | 1 | Incoming carry flag |
| valid_o | output | 1 | Result valid, one cycle after the request |
| res_o | output | 8 | Registered result |
| res_we_o | output | 1 | The result should be written back |
| flags_o | output | 4 | New flag values {N,V,Z,C}, masked by the write-enables |
| flags_we_o | output | 4 | Per-flag write-enables {N,V,Z,C} |

## Verification
The checker expects `op_i`, `acc_i`, `opd_i` and `carry_i` to be settled at each edge where `valid_i` is high. Its carry check for compare and its write-enable checks compare the registered outputs with the inputs sampled one edge earlier. The stimulus changes inputs only on falling edges. It mixes directed corner values (sign-overflow pairs, wrap points, equal compares and zero results) with seeded random requests over all sixteen codes. It also inserts idle gaps, so the hold behaviour is checked between back-to-back bursts.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_OR  = 4'd0,
    OP_AND = 4'd1,
    OP_XOR = 4'd2,
    OP_ADC = 4'd3,
    OP_SBC = 4'd4,
    OP_CMP = 4'd5,
    OP_BIT = 4'd6,
    OP_ASL = 4'd7,
    OP_LSR = 4'd8,
    OP_ROL = 4'd9,
    OP_ROR = 4'd10,
    OP_INC = 4'd11,
    OP_DEC = 4'd12
  } alu_op_e;

  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_V = 2;
  localparam int F_N = 3;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

  localparam flags_t WE_NZ   = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
  localparam flags_t WE_NZC  = '{n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
  localparam flags_t WE_NVZ  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
  localparam flags_t WE_ALL  = '{n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
  localparam flags_t WE_NONE = '{n: 1'b0, v: 1'b0, z: 1'b0, c: 1'b0};
endpackage

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    unique case (sel_i)
      2'd0:    res_o = a_i | b_i;
      2'd1:    res_o = a_i & b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = inv_b_i ? ~b_i : b_i;
  assign wide  = {1'b0, a_i} + {1'b0, b_eff} + (W+1)'(cin_i);
  assign sum_o  = wide[W-1:0];
  assign cout_o = wide[W];
  // sign of result disagrees with both (effective) inputs
  assign ovf_o  = (sum_o[MSB] ^ b_eff[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  logic         right_i,
  input  logic         rot_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic fill;
  assign fill = rot_i & cin_i;

  always_comb begin
    if (right_i) begin
      res_o  = {fill, a_i[W-1:1]};
      cout_o = a_i[0];
    end else begin
      res_o  = {a_i[W-2:0], fill};
      cout_o = a_i[W-1];
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opd_i,
  input  logic         carry_i,
  output logic         valid_o,
  output logic [W-1:0] res_o,
  output logic         res_we_o,
  output logic [3:0]   flags_o,
  output logic [3:0]   flags_we_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] lg_res, as_sum, sh_res, step_res;
  logic         as_cout, as_ovf, sh_cout;
  logic         as_inv, as_cin, sh_right, sh_rot;

  assign as_inv   = (op_i == OP_SBC) || (op_i == OP_CMP);
  assign as_cin   = (op_i == OP_CMP) ? 1'b1 : carry_i;
  assign sh_right = (op_i == OP_LSR) || (op_i == OP_ROR);
  assign sh_rot   = (op_i == OP_ROL) || (op_i == OP_ROR);
  assign step_res = (op_i == OP_DEC) ? acc_i - W'(1) : acc_i + W'(1);

  alu8_logic #(.W(W)) u_logic (
    .sel_i (op_i[1:0]),
    .a_i   (acc_i),
    .b_i   (opd_i),
    .res_o (lg_res)
  );

  alu8_addsub #(.W(W)) u_addsub (
    .a_i     (acc_i),
    .b_i     (opd_i),
    .inv_b_i (as_inv),
    .cin_i   (as_cin),
    .sum_o   (as_sum),
    .cout_o  (as_cout),
    .ovf_o   (as_ovf)
  );

  alu8_shift #(.W(W)) u_shift (
    .a_i     (acc_i),
    .cin_i   (carry_i),
    .right_i (sh_right),
    .rot_i   (sh_rot),
    .res_o   (sh_res),
    .cout_o  (sh_cout)
  );

  logic [W-1:0] res_d;
  logic         res_we_d;
  flags_t       fl_d, fwe_d;

  always_comb begin
    res_d    = '0;
    res_we_d = 1'b0;
    fl_d     = '0;
    fwe_d    = WE_NONE;
    unique case (op_i)
      OP_OR, OP_AND, OP_XOR: begin
        res_d = lg_res; res_we_d = 1'b1; fwe_d = WE_NZ;
      end
      OP_ADC, OP_SBC: begin
        res_d = as_sum; res_we_d = 1'b1; fwe_d = WE_ALL;
        fl_d.c = as_cout; fl_d.v = as_ovf;
      end
      OP_CMP: begin
        fwe_d  = WE_NZC;
        fl_d.c = as_cout;
        fl_d.z = (acc_i == opd_i);
        fl_d.n = as_sum[MSB];
      end
      OP_BIT: begin
        fwe_d  = WE_NVZ;
        fl_d.z = ~|(acc_i & opd_i);
        fl_d.n = opd_i[MSB];
        fl_d.v = opd_i[MSB-1];
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res_d = sh_res; res_we_d = 1'b1; fwe_d = WE_NZC;
        fl_d.c = sh_cout;
      end
      OP_INC, OP_DEC: begin
        res_d = step_res; res_we_d = 1'b1; fwe_d = WE_NZ;
      end
      default: ;
    endcase
    if (res_we_d) begin
      fl_d.z = ~|res_d;
      fl_d.n = res_d[MSB];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      res_o      <= '0;
      res_we_o   <= 1'b0;
      flags_o    <= '0;
      flags_we_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        res_we_o   <= res_we_d;
        flags_o    <= fl_d & fwe_d;
        flags_we_o <= fwe_d;
        if (res_we_d) res_o <= res_d;
      end
    end
  end
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opd_i,
  input logic         valid_o,
  input logic [W-1:0] res_o,
  input logic         res_we_o,
  input logic [3:0]   flags_o,
  input logic [3:0]   flags_we_o
);
  logic is_logic, is_shift, is_step, is_spare;
  assign is_logic = (op_i == OP_OR) || (op_i == OP_AND) || (op_i == OP_XOR);
  assign is_shift = (op_i == OP_ASL) || (op_i == OP_LSR) || (op_i == OP_ROL) || (op_i == OP_ROR);
  assign is_step  = (op_i == OP_INC) || (op_i == OP_DEC);
  assign is_spare = (op_i > 4'd12);

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(res_o) && $stable(flags_o) && $stable(flags_we_o)); // R1
  AST_CMP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> !res_we_o && flags_we_o == 4'b1011 && $stable(res_o)); // R4
  AST_CMP_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CMP |=> flags_o[F_C] == ($past(acc_i) >= $past(opd_i))); // R4
  AST_BIT_NO_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_BIT |=> !res_we_o && !flags_we_o[F_C] && flags_o[F_V] == $past(opd_i[W-2])); // R5
  AST_LOGIC_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_logic |=> res_we_o && flags_we_o == 4'b1010); // R6
  AST_SHIFT_KEEP_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_shift |=> !flags_we_o[F_V] && flags_we_o[F_C]); // R7
  AST_STEP_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_step |=> flags_we_o == 4'b1010); // R9
  AST_NZ_FROM_RES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && res_we_o |-> flags_o[F_Z] == (res_o == '0) && flags_o[F_N] == res_o[W-1]); // R10
  AST_SPARE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_spare |=> valid_o && !res_we_o && flags_we_o == 4'b0000 && $stable(res_o)); // R11
  AST_MASKED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o & ~flags_we_o) == 4'b0000); // R13
endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .acc_i      (acc_i),
  .opd_i      (opd_i),
  .valid_o    (valid_o),
  .res_o      (res_o),
  .res_we_o   (res_we_o),
  .flags_o    (flags_o),
  .flags_we_o (flags_we_o)
);

// File: tb/alu8_flags_bench.sv
`timescale 1ns/1ps
module alu8_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [3:0] op = '0;
  logic [7:0] acc = '0, opd = '0;
  logic       cin = 1'b0;
  logic       valid_o, res_we_o;
  logic [7:0] res_o;
  logic [3:0] flags_o, flags_we_o;

  always #2 clk = ~clk;

  alu8_flags u_alu8_flags (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .acc_i(acc), .opd_i(opd), .carry_i(cin),
    .valid_o(valid_o), .res_o(res_o), .res_we_o(res_we_o),
    .flags_o(flags_o), .flags_we_o(flags_we_o)
  );

  typedef struct {
    logic [7:0] res;
    logic       rwe;
    logic [3:0] fl;
    logic [3:0] fwe;
    int         op;
  } exp_t;

  exp_t       q[$];
  int         n_chk = 0, n_bad = 0;
  logic [7:0] model_res = '0;
  logic [7:0] last_res = '0;
  logic [3:0] last_fl = '0, last_fwe = '0;
  logic       last_rwe = 1'b0;

  function automatic string tag(int o);
    case (o)
      0, 1, 2: return "R6";
      3:       return "R2";
      4:       return "R3";
      5:       return "R4";
      6:       return "R5";
      7, 8:    return "R7";
      9, 10:   return "R8";
      11, 12:  return "R9";
      default: return "R11";
    endcase
  endfunction

  // flag order {N,V,Z,C}
  function automatic exp_t model(int o, int a, int m, int c, logic [7:0] prev);
    exp_t e;
    int r, s, fc, fz, fv, fn;
    r = prev; fc = 0; fz = 0; fv = 0; fn = 0;
    e.rwe = 1'b0; e.fwe = 4'b0000; e.op = o;
    case (o)
      0: begin r = a | m; e.rwe = 1; e.fwe = 4'b1010; end
      1: begin r = a & m; e.rwe = 1; e.fwe = 4'b1010; end
      2: begin r = a ^ m; e.rwe = 1; e.fwe = 4'b1010; end
      3: begin
        s = a + m + c; r = s & 255; fc = (s > 255);
        fv = (((r ^ m) & (r ^ a) & 128) != 0); e.rwe = 1; e.fwe = 4'b1111;
      end
      4: begin
        s = a + (m ^ 255) + c; r = s & 255; fc = (s > 255);
        fv = (((r ^ (m ^ 255)) & (r ^ a) & 128) != 0); e.rwe = 1; e.fwe = 4'b1111;
      end
      5: begin fc = (a >= m); fz = (a == m); fn = (((a - m) & 128) != 0); e.fwe = 4'b1011; end
      6: begin fz = ((a & m) == 0); fn = (m >> 7) & 1; fv = (m >> 6) & 1; e.fwe = 4'b1110; end
      7: begin r = (a << 1) & 255; fc = a >> 7; e.rwe = 1; e.fwe = 4'b1011; end
      8: begin r = a >> 1; fc = a & 1; e.rwe = 1; e.fwe = 4'b1011; end
      9: begin r = ((a << 1) | c) & 255; fc = a >> 7; e.rwe = 1; e.fwe = 4'b1011; end
      10: begin r = (a >> 1) | (c << 7); fc = a & 1; e.rwe = 1; e.fwe = 4'b1011; end
      11: begin r = (a + 1) & 255; e.rwe = 1; e.fwe = 4'b1010; end
      12: begin r = (a + 255) & 255; e.rwe = 1; e.fwe = 4'b1010; end
      default: ;
    endcase
    if (e.rwe) begin fz = (r == 0); fn = (r >> 7) & 1; end
    e.res = 8'(r);
    e.fl  = {1'(fn), 1'(fv), 1'(fz), 1'(fc)} & e.fwe;
    return e;
  endfunction

  task automatic send(int o, int a, int m, int c);
    exp_t e;
    @(negedge clk);
    valid = 1'b1; op = 4'(o); acc = 8'(a); opd = 8'(m); cin = 1'(c);
    e = model(o, a, m, c, model_res);
    if (e.rwe) model_res = e.res;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
    end
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (valid_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R1", "unexpected valid_o", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(res_o == e.res && res_we_o == e.rwe && flags_o == e.fl && flags_we_o == e.fwe,
                tag(e.op), $sformatf("op%0d {res,rwe,fl,fwe}", e.op),
                {res_o, 3'b0, res_we_o, flags_o, flags_we_o}, {e.res, 3'b0, e.rwe, e.fl, e.fwe});
          if (e.rwe)
            check(flags_o[1] == (res_o == 0) && flags_o[3] == res_o[7], "R10", "NZ vs result",
                  {flags_o[3], flags_o[1]}, {res_o[7], res_o == 0});
          last_res = e.res; last_rwe = e.rwe; last_fl = e.fl; last_fwe = e.fwe;
        end
      end else begin
        check(res_o == last_res && res_we_o == last_rwe && flags_o == last_fl && flags_we_o == last_fwe,
              "R1", "idle hold", {res_o, flags_o}, {last_res, last_fl});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 0 && res_o == 0 && res_we_o == 0 && flags_o == 0 && flags_we_o == 0,
          "R12", "reset state", {valid_o, res_o, flags_o}, 0);
    rst_n = 1'b1;
    idle(2);
    // R2 add: signed overflow, carry out with zero
    send(3, 8'h50, 8'h50, 0);
    send(3, 8'hFF, 8'h01, 0);
    send(3, 8'h10, 8'h20, 1);
    send(3, 8'h80, 8'h80, 0);
    // R3 subtract
    send(4, 8'h50, 8'hB0, 1);
    send(4, 8'h00, 8'h01, 1);
    send(4, 8'h05, 8'h05, 0);
    send(4, 8'h80, 8'h01, 1);
    // R4 compare: equal, less, greater; result must stay
    send(5, 8'h42, 8'h42, 0);
    send(5, 8'h10, 8'h20, 1);
    send(5, 8'hF0, 8'h01, 0);
    // R5 bit test
    send(6, 8'h3F, 8'hC0, 1);
    send(6, 8'hFF, 8'h41, 0);
    // R6 logic
    send(0, 8'h00, 8'h00, 1);
    send(1, 8'hF0, 8'h8F, 0);
    send(2, 8'hAA, 8'hAA, 1);
    idle(3);
    // R7 / R8 shifts and rotates
    send(7, 8'h80, 8'h00, 1);
    send(8, 8'h01, 8'h00, 1);
    send(9, 8'h80, 8'h00, 1);
    send(10, 8'h01, 8'h00, 1);
    send(9, 8'h40, 8'h00, 0);
    send(10, 8'h02, 8'h00, 0);
    // R9 wrap points
    send(11, 8'hFF, 8'h00, 1);
    send(12, 8'h00, 8'h00, 1);
    send(11, 8'h7F, 8'h00, 0);
    // R11 spare codes
    send(13, 8'h12, 8'h34, 1);
    send(15, 8'hFF, 8'hFF, 1);
    idle(2);
    for (int i = 0; i < 600; i++) begin
      send($urandom_range(0, 15), $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 1));
      if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    check(q.size() == 0, "R1", "pending results", q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule